// File: doc/BRIEF.md
# Duty-Safe Switchable Card Clock Divider

This block produces a card clock from a single oscillator input, which may come from a crystal or from an external source. Two select bits choose the division ratio. An activation enable turns the output on and off. The output is always a registered square wave with exactly half of each period high. A change of ratio or of enable is acted on only at the end of a complete output period, after the low half. Because of this, no period is ever cut short or stretched, and the duty cycle stays inside the 45-55% window even while the ratio is being changed.

The select bits and the enable are asynchronous to the oscillator, so each passes through a two-stage synchroniser first. A small state machine then steps through three named states:

- `ST_IDLE`: output low, clock stopped.
- `ST_HIGH`: high half of a period.
- `ST_LOW`: low half of a period.

A down-counter times each half period. The state machine has these transitions:

| Transition | Condition |
|---|---|
| `ST_IDLE -> ST_HIGH` | synchronised enable set; the current synchronised ratio is captured |
| `ST_IDLE -> ST_IDLE` | enable clear |
| `ST_HIGH -> ST_LOW` | half-period counter expires |
| `ST_LOW -> ST_HIGH` | counter expires with enable set; the new ratio is captured |
| `ST_LOW -> ST_IDLE` | counter expires with enable clear |

In every other case the state holds and the counter decrements.

Top module: `card_clk_divider`

## Requirements
- R1: While `rst_n` is low, and after its release until the enable is seen, `card_clk` is 0.
- R2: Select code `div_sel` 2'b00, 2'b01, 2'b10 and 2'b11 gives an output period of 2, 4, 8 and 16 oscillator cycles. Each period is high for its first half and low for its second half.
- R3: `div_sel` passes through two register stages. A new ratio is captured only when a period begins, that is on entry to `ST_HIGH` from `ST_IDLE` or at the end of a `ST_LOW` phase. A change in the middle of a period alters neither half of that period.
- R4: Every completed period has equal high and low time, so the measured duty lies within 45% to 55%.
- R5: With `act_en` set while idle, `card_clk` rises on the third rising oscillator edge after `act_en` is sampled. That edge count is two synchroniser stages plus the state register.
- R6: When `act_en` is cleared, the period in progress completes at full length. The output then stays low in `ST_IDLE`.
- R7: While idle, changes on `div_sel` have no effect on `card_clk`.
- R8: The enable is sampled only at period boundaries. A low pulse on `act_en` that starts and ends inside one period leaves the output waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock, from a crystal or an external source |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Division ratio select, asynchronous |
| act_en | input | 1 | Activation enable for the card clock, asynchronous |
| card_clk | output | 1 | Divided, duty-safe card clock |

## Verification
A ratio change and a disable can land on the same period boundary. In that case the block must end the period at the old ratio and go idle, and must not begin a period at the new ratio. The bench provokes this by changing `div_sel` and clearing `act_en` in the same cycle, in the middle of a period. The per-cycle reference model and the high/low run measurement then check that the final period has its old length and that the output goes quiet afterwards. A second collision, an enable pulse arriving together with a select change while idle, shows that the ratio captured at start-up is the synchronised select value present at that moment.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } ckdiv_state_e;
endpackage

// File: rtl/ckdiv_sync.sv
module ckdiv_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ckdiv_half_cnt.sv
module ckdiv_half_cnt #(
    parameter int SEL_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    logic [CNT_W-1:0] load_val;

    // half period = 2**sel oscillator cycles, counter runs down to 0
    assign load_val = CNT_W'((32'd1 << sel) - 32'd1);
    assign zero     = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider
    import ckdiv_pkg::*;
#(
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             act_en,
    output logic             card_clk
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    ckdiv_state_e     state, state_nx;
    logic [SEL_W-1:0] sel_s, ratio_q, cnt_sel;
    logic             en_s;
    logic [CNT_W-1:0] cnt;
    logic             zero, load, dec, capture;

    ckdiv_sync #(.WIDTH(SEL_W), .STAGES(SYNC_STAGES)) u_sel_sync (
        .clk(osc_clk), .rst_n(rst_n), .d(div_sel), .q(sel_s)
    );

    ckdiv_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_en_sync (
        .clk(osc_clk), .rst_n(rst_n), .d(act_en), .q(en_s)
    );

    ckdiv_half_cnt #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_half_cnt (
        .clk(osc_clk), .rst_n(rst_n), .load(load), .dec(dec),
        .sel(cnt_sel), .cnt(cnt), .zero(zero)
    );

    // next state and counter control
    always_comb begin
        state_nx = state;
        capture  = 1'b0;
        load     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (en_s) begin
                    state_nx = ST_HIGH;
                    capture  = 1'b1;
                    load     = 1'b1;
                end
            end
            ST_HIGH: begin
                if (zero) begin
                    state_nx = ST_LOW;
                    load     = 1'b1;
                end
            end
            ST_LOW: begin
                if (zero) begin
                    if (en_s) begin
                        state_nx = ST_HIGH;
                        capture  = 1'b1;
                        load     = 1'b1;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
        dec     = (state != ST_IDLE) && !zero;
        cnt_sel = capture ? sel_s : ratio_q;
    end

    // state register
    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ratio_q <= '0;
        end else begin
            state <= state_nx;
            if (capture) ratio_q <= sel_s;
        end
    end

    // output decode
    always_comb begin
        card_clk = (state == ST_HIGH);
    end
endmodule

// File: rtl/ckdiv_chk.sv
module ckdiv_chk
    import ckdiv_pkg::*;
#(
    parameter int SEL_W = 2,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input ckdiv_state_e     state,
    input logic [CNT_W-1:0] cnt,
    input logic [SEL_W-1:0] ratio_q,
    input logic             en_s,
    input logic             card_clk
);
    // R3
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH || (state == ST_LOW && cnt != '0)) |=> $stable(ratio_q));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (32'(cnt) < (32'd1 << ratio_q)));

    // R4
    fall_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_clk) |-> ($past(cnt) == '0));

    // R5
    rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> $past(en_s));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !en_s) |=> !card_clk);

    // R6
    low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW && cnt != '0) |=> !card_clk);
endmodule

bind card_clk_divider ckdiv_chk #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
    .clk(osc_clk), .rst_n(rst_n), .state(state), .cnt(cnt),
    .ratio_q(ratio_q), .en_s(en_s), .card_clk(card_clk)
);

// File: tb/card_clk_divider_bench.sv
`timescale 1ns/1ps
module card_clk_divider_bench;
    logic       osc_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       act_en  = 1'b0;
    logic       card_clk;

    int    n_vec  = 0;
    int    n_fail = 0;
    int    cyc    = 0;
    string cur_req = "R1";

    card_clk_divider u_card_clk_divider (
        .osc_clk(osc_clk), .rst_n(rst_n), .div_sel(div_sel),
        .act_en(act_en), .card_clk(card_clk)
    );

    always #2.5 osc_clk = ~osc_clk;

    // behavioural reference: 0 idle, 1 high, 2 low
    int m_state = 0, m_rem = 0, m_half = 1;
    int en_q[$], sel_q[$];
    bit m_gap = 1'b1;

    always @(posedge osc_clk) begin
        cyc++;
        if (!rst_n) begin
            m_state = 0; m_rem = 0; m_half = 1; m_gap = 1'b1;
            en_q = '{0, 0}; sel_q = '{0, 0};
        end else begin
            int es, ss;
            es = en_q[0]; ss = sel_q[0];
            case (m_state)
                0: if (es != 0) begin m_state = 1; m_half = 1 << ss; m_rem = m_half - 1; end
                1: if (m_rem == 0) begin m_state = 2; m_rem = m_half - 1; end
                   else m_rem--;
                default: if (m_rem == 0) begin
                       if (es != 0) begin m_state = 1; m_half = 1 << ss; m_rem = m_half - 1; end
                       else begin m_state = 0; m_gap = 1'b1; end
                   end else m_rem--;
            endcase
            void'(en_q.pop_front()); void'(sel_q.pop_front());
            en_q.push_back(int'(act_en)); sel_q.push_back(int'(div_sel));
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // per-cycle compare and duty measurement, away from the active edge
    logic prev_lvl = 1'b0;
    int   run = 0, hi_len = 0;
    always @(negedge osc_clk) begin
        int exp_out;
        exp_out = (m_state == 1) ? 1 : 0;
        check(int'(card_clk) == exp_out, cur_req, int'(card_clk), exp_out);
        if (card_clk !== prev_lvl) begin
            if (!card_clk) hi_len = run;
            else begin
                if (!m_gap && hi_len > 0) begin
                    // R4: equal halves, duty inside 45..55 %
                    check(run == hi_len, "R4", run, hi_len);
                    check((100*hi_len/(hi_len+run)) >= 45 && (100*hi_len/(hi_len+run)) <= 55,
                          "R4", 100*hi_len/(hi_len+run), 50);
                end
                m_gap = 1'b0;
            end
            run = 1;
        end else run++;
        prev_lvl = card_clk;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge osc_clk);
        #1;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        #2000000;
        n_vec++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        wait_cyc(4);
        check(card_clk == 1'b0, "R1", int'(card_clk), 0);
        rst_n = 1'b1;
        wait_cyc(5);
        check(card_clk == 1'b0, "R1", int'(card_clk), 0);

        // R5: start-up latency, divide by 2
        cur_req = "R5";
        act_en = 1'b1;
        wait_cyc(2);
        check(card_clk == 1'b0, "R5", int'(card_clk), 0);
        wait_cyc(1);
        check(card_clk == 1'b1, "R5", int'(card_clk), 1);

        // R2: every ratio
        cur_req = "R2";
        for (int s = 0; s < 4; s++) begin
            div_sel = 2'(s);
            wait_cyc(60);
        end

        // R3: mid-period select changes
        cur_req = "R3";
        div_sel = 2'b11; wait_cyc(37);
        div_sel = 2'b00; wait_cyc(3);
        div_sel = 2'b10; wait_cyc(5);
        div_sel = 2'b01; wait_cyc(1);
        div_sel = 2'b11; wait_cyc(40);

        // R8: short enable dropout inside a 16-cycle period
        cur_req = "R8";
        wait_cyc(3);
        act_en = 1'b0; wait_cyc(2);
        act_en = 1'b1; wait_cyc(40);

        // R6: disable completes the period then stays low
        cur_req = "R6";
        act_en = 1'b0;
        wait_cyc(30);
        check(card_clk == 1'b0, "R6", int'(card_clk), 0);

        // R7: select activity while idle
        cur_req = "R7";
        for (int s = 0; s < 8; s++) begin
            div_sel = 2'(s);
            wait_cyc(3);
            check(card_clk == 1'b0, "R7", int'(card_clk), 0);
        end

        // collision: enable and select change together while idle
        cur_req = "R3";
        div_sel = 2'b01; act_en = 1'b1;
        wait_cyc(50);
        // collision: select change and disable in the same cycle
        cur_req = "R6";
        wait_cyc(1);
        div_sel = 2'b11; act_en = 1'b0;
        wait_cyc(40);
        check(card_clk == 1'b0, "R6", int'(card_clk), 0);

        // R2: restart at divide by 8
        cur_req = "R2";
        div_sel = 2'b10; act_en = 1'b1;
        wait_cyc(70);

        finish_run();
    end
endmodule